// File: doc/BRIEF.md
# HDLC Receive Buffer Interrupt Controller

This block takes decoded events from a byte-level HDLC deframer and hands the received message bytes to a host processor. The deframer presents one event per cycle: a received byte, a closing-flag (end-of-message) pulse with a frame-check-failed flag, or an abort pulse. Each byte goes into an 8-entry ring split into a lower half (locations 0-3) and an upper half (locations 4-7). The block raises an interrupt when a half fills, when a message closes, or when a message is aborted. While the host empties the full half, the deframer keeps filling the other half.

The host reads one 16-bit word per request. The word is either a buffer byte or the control/status word, and it is registered, so it appears one cycle after the request. Reading the status word acknowledges the pending interrupt. A separate write strobe sets or clears the interrupt enable. The two frame-check bytes are only recognised as such once the closing flag arrives, so the end-of-message status can repeat the index of the previous half-full report.

Top module: `hdlc_rx_irq_buf`

## Requirements
- R1: After reset, the interrupt output is low and a status-word read returns 0x0000.
- R2: Successive bytes are stored at locations 0,1,...,7, then 0 again. A buffer read of location a (host_sel_csr=0, host_addr=a) returns {8'h00, byte} one cycle after the request. Buffer reads do not move the write position.
- R3: Storing a byte at location 3 or 7 raises a pending half-full event. Status fields for this event: index bits [2:0] = 3 or 7, idle bit 3 = 0, check-failed bit 4 = 0, aborted bit 5 = 0.
- R4: An end-of-message pulse raises a pending event with bit 3 = 1 and bit 4 = rx_fcs_bad, provided at least four bytes have arrived since reset or since the last end/abort pulse. Bits [2:0] give the last location written.
- R5: An abort pulse under the same four-byte condition raises a pending event with bit 5 = 1, bits 3 and 4 = 0, and bits [2:0] = last location written.
- R6: Every end-of-message or abort pulse makes the next byte go to location 0. A pulse that arrives with fewer than four bytes since the previous one (or since reset) raises nothing and leaves the status word unchanged.
- R7: Bit 15 of the status word shows the pending event. A status-word read returns the word as it was before the read and clears bit 15. Status bits [5:0] are kept.
- R8: Bit 7 of the status word is the interrupt enable, written by host_irq_en_wr with host_irq_en_val. irq_o is high exactly when bits 15 and 7 are both set.
- R9: While an end-of-message or abort event is pending, a half-full event does not overwrite bits [5:0].
- R10: A closing flag right after a half-full report repeats index 3 or 7. A frame-check field that straddles the halves ends with index 0 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte_vld | input | 1 | Deframer byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_eom | input | 1 | Closing flag seen (one-cycle pulse) |
| rx_fcs_bad | input | 1 | Frame check failed, qualified by rx_eom |
| rx_abort | input | 1 | Abort seen (one-cycle pulse) |
| host_rd_en | input | 1 | Host read request |
| host_sel_csr | input | 1 | 1 selects the status word, 0 a buffer byte |
| host_addr | input | 3 | Buffer location for a byte read |
| host_irq_en_wr | input | 1 | Write strobe for the interrupt enable |
| host_irq_en_val | input | 1 | New interrupt enable value |
| host_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the deframer never presents more than one of byte, end-of-message and abort in the same cycle. The write-position and restart properties depend on that. The assertions also assume that host reads do not collide with events in a way that hides an acknowledge. The stimulus issues exactly one operation per cycle and returns every strobe low before the next operation starts, so the single-event assumption always holds. The random mix weights bytes heavily, so half-full, runt, straddle and priority cases all recur.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    localparam int DATA_W      = 8;
    localparam int BUF_DEPTH   = 8;             // power of two
    localparam int HALF_DEPTH  = BUF_DEPTH / 2;
    localparam int IDX_W       = $clog2(BUF_DEPTH);
    localparam int CNT_W       = $clog2(HALF_DEPTH + 1);
    localparam int CSR_W       = 16;

    localparam int CSR_PEND_BIT  = 15;
    localparam int CSR_EN_BIT    = 7;
    localparam int CSR_ABORT_BIT = 5;
    localparam int CSR_BAD_BIT   = 4;
    localparam int CSR_IDLE_BIT  = 3;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_HALF,
        EV_END,
        EV_ABORT
    } rx_event_e;

    typedef struct packed {
        logic             idle;
        logic             fcs_bad;
        logic             aborted;
        logic [IDX_W-1:0] idx;
    } rx_stat_t;

    function automatic logic half_end(input logic [IDX_W-1:0] idx);
        return (idx % IDX_W'(HALF_DEPTH)) == IDX_W'(HALF_DEPTH - 1);
    endfunction

    function automatic logic [CSR_W-1:0] pack_csr(input logic pend,
                                                  input logic en,
                                                  input rx_stat_t st);
        logic [CSR_W-1:0] w;
        w                = '0;
        w[CSR_PEND_BIT]  = pend;
        w[CSR_EN_BIT]    = en;
        w[CSR_ABORT_BIT] = st.aborted;
        w[CSR_BAD_BIT]   = st.fcs_bad;
        w[CSR_IDLE_BIT]  = st.idle;
        w[IDX_W-1:0]     = st.idx;
        return w;
    endfunction
endpackage

// File: rtl/rx_byte_store.sv
module rx_byte_store
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              restart,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [IDX_W-1:0]  last_idx,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] rd_byte
);
    logic [BUF_DEPTH-1:0][DATA_W-1:0] mem_q;

    assign wr_idx  = last_idx + IDX_W'(1);
    assign rd_byte = mem_q[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            last_idx <= IDX_W'(BUF_DEPTH - 1);
            mem_q    <= '0;
        end else if (restart) begin
            last_idx <= IDX_W'(BUF_DEPTH - 1);
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
            last_idx      <= wr_idx;
        end
    end
endmodule

// File: rtl/rx_event_ctrl.sv
module rx_event_ctrl
    import hdlc_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_wr,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             eom,
    input  logic             fcs_bad,
    input  logic             abort_in,
    input  logic             csr_rd,
    input  logic             en_wr,
    input  logic             en_val,
    output logic             restart,
    output logic             pend_q,
    output logic             en_q,
    output rx_stat_t         stat_q
);
    logic [CNT_W-1:0] cnt_q;
    logic             term_q;
    logic             armed;
    rx_event_e        ev;

    assign armed   = (cnt_q == CNT_W'(HALF_DEPTH));
    assign restart = eom | abort_in;

    always_comb begin
        if (eom && armed)                      ev = EV_END;
        else if (abort_in && armed)            ev = EV_ABORT;
        else if (byte_wr && half_end(wr_idx))  ev = EV_HALF;
        else                                   ev = EV_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            term_q <= 1'b0;
            pend_q <= 1'b0;
            en_q   <= 1'b0;
            stat_q <= '0;
        end else begin
            if (restart)
                cnt_q <= '0;
            else if (byte_wr && !armed)
                cnt_q <= cnt_q + CNT_W'(1);

            if (en_wr)
                en_q <= en_val;

            unique case (ev)
                EV_HALF: begin
                    pend_q <= 1'b1;
                    if (!(pend_q && term_q)) begin
                        stat_q <= '{idle: 1'b0, fcs_bad: 1'b0, aborted: 1'b0, idx: wr_idx};
                        term_q <= 1'b0;
                    end
                end
                EV_END: begin
                    pend_q <= 1'b1;
                    term_q <= 1'b1;
                    stat_q <= '{idle: 1'b1, fcs_bad: fcs_bad, aborted: 1'b0, idx: last_idx};
                end
                EV_ABORT: begin
                    pend_q <= 1'b1;
                    term_q <= 1'b1;
                    stat_q <= '{idle: 1'b0, fcs_bad: 1'b0, aborted: 1'b1, idx: last_idx};
                end
                default: begin
                    if (csr_rd) begin
                        pend_q <= 1'b0;
                        term_q <= 1'b0;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/hdlc_rx_irq_buf.sv
module hdlc_rx_irq_buf
    import hdlc_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_byte_vld,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_eom,
    input  logic              rx_fcs_bad,
    input  logic              rx_abort,
    input  logic              host_rd_en,
    input  logic              host_sel_csr,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic              host_irq_en_wr,
    input  logic              host_irq_en_val,
    output logic [CSR_W-1:0]  host_rdata,
    output logic              irq_o
);
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] rd_byte;
    logic              restart;
    logic              pend_q;
    logic              en_q;
    rx_stat_t          stat_q;
    logic [CSR_W-1:0]  csr_val;

    rx_byte_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (rx_byte_vld),
        .wr_data  (rx_byte),
        .restart  (restart),
        .rd_addr  (host_addr),
        .last_idx (last_idx),
        .wr_idx   (wr_idx),
        .rd_byte  (rd_byte)
    );

    rx_event_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .byte_wr  (rx_byte_vld),
        .wr_idx   (wr_idx),
        .last_idx (last_idx),
        .eom      (rx_eom),
        .fcs_bad  (rx_fcs_bad),
        .abort_in (rx_abort),
        .csr_rd   (host_rd_en && host_sel_csr),
        .en_wr    (host_irq_en_wr),
        .en_val   (host_irq_en_val),
        .restart  (restart),
        .pend_q   (pend_q),
        .en_q     (en_q),
        .stat_q   (stat_q)
    );

    assign csr_val = pack_csr(pend_q, en_q, stat_q);
    assign irq_o   = pend_q & en_q;

    always_ff @(posedge clk) begin
        if (rst)
            host_rdata <= '0;
        else if (host_rd_en)
            host_rdata <= host_sel_csr ? csr_val : CSR_W'(rd_byte);
    end
endmodule

// File: rtl/hdlc_rx_irq_chk.sv
module hdlc_rx_irq_chk
    import hdlc_rx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rx_byte_vld,
    input logic             rx_eom,
    input logic             rx_abort,
    input logic             host_rd_en,
    input logic             host_sel_csr,
    input logic             irq_o,
    input logic [IDX_W-1:0] last_idx,
    input logic             pend_q,
    input logic             en_q
);
    logic [IDX_W-1:0] nxt_idx;
    assign nxt_idx = last_idx + IDX_W'(1);

    assert_single_event_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_byte_vld, rx_eom, rx_abort}));

    assert_half_raise_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_byte_vld && half_end(nxt_idx)) |=> pend_q);

    assert_rd_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (host_rd_en && host_sel_csr && !rx_byte_vld && !rx_eom && !rx_abort) |=> !pend_q);

    assert_gate_off_R8: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !irq_o);

    assert_idx_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!rx_byte_vld && !rx_eom && !rx_abort) |=> $stable(last_idx));

    assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_eom || rx_abort) |=> (last_idx == IDX_W'(BUF_DEPTH - 1)));
endmodule

bind hdlc_rx_irq_buf hdlc_rx_irq_chk u_chk (.*);

// File: tb/hdlc_rx_irq_buf_tb.sv
module hdlc_rx_irq_buf_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        rx_byte_vld, rx_eom, rx_fcs_bad, rx_abort;
    logic [7:0]  rx_byte;
    logic        host_rd_en, host_sel_csr, host_irq_en_wr, host_irq_en_val;
    logic [2:0]  host_addr;
    logic [15:0] host_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    logic [7:0] m_buf [8];
    int   m_last, m_cnt, m_rep;
    bit   m_pend, m_term, m_idle, m_bad, m_ab, m_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_rx_irq_buf u_dut (
        .clk(clk), .rst(rst), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
        .rx_eom(rx_eom), .rx_fcs_bad(rx_fcs_bad), .rx_abort(rx_abort),
        .host_rd_en(host_rd_en), .host_sel_csr(host_sel_csr), .host_addr(host_addr),
        .host_irq_en_wr(host_irq_en_wr), .host_irq_en_val(host_irq_en_val),
        .host_rdata(host_rdata), .irq_o(irq_o)
    );

    function automatic logic [15:0] exp_csr();
        return {m_pend, 7'b0, m_en, 1'b0, m_ab, m_bad, m_idle, 3'(m_rep)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_irq(input string tag);
        chk(irq_o == (m_pend && m_en), tag, 16'(irq_o), 16'(m_pend && m_en));
    endtask

    task automatic push(input logic [7:0] b);
        int nxt;
        rx_byte_vld = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_byte_vld = 1'b0;
        nxt = (m_last + 1) % 8;
        m_buf[nxt] = b;
        m_last = nxt;
        if (m_cnt < 4) m_cnt++;
        if (nxt % 4 == 3) begin           // R3 half-full
            m_pend = 1'b1;
            if (!m_term) begin            // R9 terminal status kept
                m_idle = 0; m_bad = 0; m_ab = 0; m_rep = nxt;
            end
        end
        chk_irq("R8 after byte");
    endtask

    task automatic finish_msg(input bit is_abort, input bit bad);
        rx_eom = !is_abort; rx_abort = is_abort; rx_fcs_bad = bad;
        @(negedge clk);
        rx_eom = 1'b0; rx_abort = 1'b0; rx_fcs_bad = 1'b0;
        if (m_cnt == 4) begin             // R4 / R5, runt ignored per R6
            m_pend = 1; m_term = 1; m_rep = m_last;
            m_idle = !is_abort; m_bad = !is_abort && bad; m_ab = is_abort;
        end
        m_last = 7; m_cnt = 0;
        chk_irq("R8 after end");
    endtask

    task automatic rd_csr(input string tag);
        logic [15:0] e;
        e = exp_csr();
        host_rd_en = 1'b1; host_sel_csr = 1'b1;
        @(negedge clk);
        host_rd_en = 1'b0; host_sel_csr = 1'b0;
        chk(host_rdata == e, tag, host_rdata, e);
        m_pend = 0; m_term = 0;           // R7
        chk_irq("R8 after csr read");
    endtask

    task automatic rd_buf(input int a);
        logic [15:0] e;
        e = {8'h00, m_buf[a]};
        host_rd_en = 1'b1; host_sel_csr = 1'b0; host_addr = 3'(a);
        @(negedge clk);
        host_rd_en = 1'b0;
        chk(host_rdata == e, "R2 buffer read", host_rdata, e);
    endtask

    task automatic set_en(input bit v);
        host_irq_en_wr = 1'b1; host_irq_en_val = v;
        @(negedge clk);
        host_irq_en_wr = 1'b0;
        m_en = v;
        chk_irq("R8 enable write");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1; rx_byte_vld = 0; rx_byte = 0; rx_eom = 0; rx_fcs_bad = 0; rx_abort = 0;
        host_rd_en = 0; host_sel_csr = 0; host_addr = 0; host_irq_en_wr = 0; host_irq_en_val = 0;
        for (int i = 0; i < 8; i++) m_buf[i] = 8'h00;
        m_last = 7; m_cnt = 0; m_rep = 0;
        m_pend = 0; m_term = 0; m_idle = 0; m_bad = 0; m_ab = 0; m_en = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk(irq_o == 1'b0, "R1 irq after reset", 16'(irq_o), 16'h0);
        rd_csr("R1 status after reset");

        set_en(1);
        // R3 first half fills at location 3
        for (int i = 0; i < 4; i++) push(8'hA0 + 8'(i));
        chk(irq_o == 1'b1, "R3 half-full irq", 16'(irq_o), 16'h1);
        for (int i = 0; i < 4; i++) rd_buf(i);          // R2
        rd_csr("R3 half-full status");
        rd_csr("R7 pending cleared");
        // R10 closing flag right after half-full repeats index 3
        finish_msg(0, 0);
        rd_csr("R10 same index end");
        // R10 straddling check field: 5 bytes then close -> index 4, R4 bad check
        for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
        rd_csr("R3 half in second msg");
        finish_msg(0, 1);
        rd_csr("R4 R10 straddle end index 4");
        // R9 terminal status survives a later half-full before the read
        for (int i = 0; i < 6; i++) push(8'h30 + 8'(i));
        rd_csr("R3 half before priority");
        finish_msg(0, 0);
        for (int i = 0; i < 4; i++) push(8'h50 + 8'(i));
        rd_csr("R9 end kept over half");
        // R6 runt end raises nothing; next byte at location 0
        finish_msg(0, 0);
        push(8'hC1); push(8'hC2);
        finish_msg(0, 1);
        rd_csr("R6 runt end ignored");
        push(8'hD7);
        rd_buf(0);                                       // R6 restart at 0
        // R5 abort with wrap through upper half, R2 wrap
        for (int i = 0; i < 9; i++) push(8'hE0 + 8'(i));
        rd_buf(0); rd_buf(7);
        finish_msg(1, 0);
        set_en(0);
        chk(irq_o == 1'b0, "R8 gated off", 16'(irq_o), 16'h0);
        rd_csr("R5 abort status");
        set_en(1);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 55)      push(8'($urandom));
            else if (r < 63) finish_msg(0, 1'($urandom));
            else if (r < 67) finish_msg(1, 0);
            else if (r < 82) rd_csr("R7 random status");
            else if (r < 94) rd_buf(int'($urandom % 8));
            else if (r < 97) set_en(1'($urandom));
            else begin
                @(negedge clk);
                chk_irq("R8 idle cycle");
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule